// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one load request from a 32-lane warp, with a byte address and an active bit for every lane, and reduces it to the fewest aligned memory transactions that cover every active lane. Each lane address is mapped to an aligned segment. A mode input sets the segment to a 32-byte sector or a 128-byte line. Lanes that land in the same segment share one transaction. The transactions leave one per cycle on a valid/ready port. Each one carries its aligned base address and a 32-bit mask of the lanes it serves.

When the last transaction of a warp has been handed off, the block raises a one-cycle done strobe. With the strobe it reports the transaction count, the bytes the active lanes use (active lanes times element size) and the bytes fetched (transactions times segment size). Dividing the first byte count by the second gives the fetch efficiency of the warp. The block accepts a new warp only after the current one has finished.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, reqReady is 1 and txnValid and doneValid are 0. A warp is accepted on a clock edge where reqValid and reqReady are both 1. reqReady then stays 0 until the cycle after doneValid.
- R2: The segment is the aligned block that holds a lane address. When lineMode is 0 it is a 32-byte sector and txnBase is the address with its low 5 bits cleared. When lineMode is 1 it is a 128-byte line and txnBase is the address with its low 7 bits cleared. lineMode is sampled when the warp is accepted.
- R3: All active lanes whose addresses fall in the same segment share one transaction. The number of transactions equals the number of distinct segments touched, so it is at most 32.
- R4: Transactions are emitted in ascending order of the lowest-numbered active lane each one serves. Bit i of txnMask stands for lane i.
- R5: Inactive lanes are ignored whatever their addresses. A warp with no active lanes raises doneValid in the first cycle after acceptance, with a transaction count of 0.
- R6: During the doneValid cycle, doneTxnCount is the number of transactions issued, doneBytesUsed is the number of active lanes times 4, and doneBytesFetched is the transaction count times the segment size.
- R7: While txnValid is 1 and txnReady is 0, the next cycle presents the same transaction again. No transaction is lost or duplicated.
- R8: Within one warp the txnMask values are pairwise disjoint, and their union equals the active mask.
- R9: Four example patterns give fixed transaction counts. 32 consecutive 4-byte elements from an aligned base give 4 in sector mode and 1 in line mode. The same pattern shifted by one element gives 5 in sector mode and 2 in line mode. A lane stride of at least the segment size gives 32. A 24-byte stride from base 0 gives 24 in sector mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineMode | input | 1 | 0: 32-byte sectors, 1: 128-byte lines; sampled on acceptance |
| reqValid | input | 1 | A warp request is present |
| reqReady | output | 1 | The block can accept a warp |
| reqActive | input | 32 | Active bit per lane, bit i is lane i |
| reqAddr | input | 1024 | Lane byte addresses, lane i at bits [32*i+31 : 32*i] |
| txnValid | output | 1 | A transaction is presented |
| txnReady | input | 1 | The consumer takes the transaction |
| txnBase | output | 32 | Aligned segment base address |
| txnMask | output | 32 | Lanes served by this transaction |
| doneValid | output | 1 | One-cycle strobe: the warp has finished |
| doneTxnCount | output | 6 | Transactions issued for the warp |
| doneBytesUsed | output | 13 | Active lanes times element size |
| doneBytesFetched | output | 13 | Transactions times segment size |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32-bit addresses, 4-byte elements, 32-byte sectors and 128-byte lines. With these values the worst case is reachable, where 32 separate transactions give a fetched count of 4096 bytes in line mode. The exact patterns from the requirements can also be driven: the unit-stride, shifted, 24-byte and wide strides, a reversed address order, scattered inactive lanes and an empty warp. A reference model in the bench forms segments from the requirements and compares each transaction's base and mask in order. It does this with the consumer always ready and again with periodic back-pressure.

// File: rtl/coalesce_pkg.sv
package coalesce_pkg;
  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic capture;  // latch a new warp
    logic issue;    // current transaction handed off
  } strobe_t;
endpackage

// File: rtl/coalesce_ctrl.sv
module coalesce_ctrl
  import coalesce_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    txnReady,
  input  logic    pendingAny,
  output logic    reqReady,
  output logic    txnValid,
  output logic    doneValid,
  output strobe_t strobe
);
  typedef enum logic {IDLE, BUSY} state_t;
  state_t state, stateNext;

  always_comb begin
    reqReady       = (state == IDLE);
    txnValid       = (state == BUSY) && pendingAny;
    doneValid      = (state == BUSY) && !pendingAny;
    strobe.capture = reqValid && reqReady;
    strobe.issue   = txnValid && txnReady;
    stateNext      = state;
    if (strobe.capture) stateNext = BUSY;
    else if (doneValid) stateNext = IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE;
    else       state <= stateNext;
  end

  // R1: acceptance closes the request port on the next cycle
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !reqReady);
  // R7: a stalled transaction remains presented
  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && !txnReady) |=> txnValid);
  // R1: done strobe reopens the request port
  assert_done_reopens_R1: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> reqReady);
endmodule

// File: rtl/coalesce_dp.sv
module coalesce_dp
  import coalesce_pkg::*;
#(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int ELEM_BYTES   = 4,
  parameter int SECTOR_BYTES = 32,
  parameter int LINE_BYTES   = 128,
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int BYTE_W = $clog2(LANES * LINE_BYTES + 1),
  localparam int LANE_W = $clog2(LANES)
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic                    lineMode,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]        reqActive,
  output logic                    pendingAny,
  output logic [ADDR_W-1:0]       txnBase,
  output logic [LANES-1:0]        txnMask,
  output logic [CNT_W-1:0]        txnCount,
  output logic [BYTE_W-1:0]       bytesUsed,
  output logic [BYTE_W-1:0]       bytesFetched
);
  localparam logic [ADDR_W-1:0] SECTOR_KEEP = ~ADDR_W'(SECTOR_BYTES - 1);
  localparam logic [ADDR_W-1:0] LINE_KEEP   = ~ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W-1:0] addrReg [LANES];
  logic [LANES-1:0]  pending;
  logic              modeReg;
  logic [CNT_W-1:0]  activeCount;
  logic [LANE_W-1:0] leadIdx;
  logic [ADDR_W-1:0] leadAddr, segKeep;

  assign pendingAny = |pending;
  assign segKeep    = modeReg ? LINE_KEEP : SECTOR_KEEP;

  // lowest pending lane leads the next transaction
  always_comb begin
    leadIdx = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (pending[i]) leadIdx = LANE_W'(i);
  end
  assign leadAddr = addrReg[leadIdx];
  assign txnBase  = leadAddr & segKeep;

  // each pending lane compares its segment against the leader's
  for (genvar g = 0; g < LANES; g++) begin : gLaneHit
    assign txnMask[g] = pending[g] && (((addrReg[g] ^ leadAddr) & segKeep) == '0);
  end

  always_ff @(posedge clk) begin
    if (strobe.capture)
      for (int i = 0; i < LANES; i++) addrReg[i] <= reqAddr[i*ADDR_W +: ADDR_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending     <= '0;
      modeReg     <= 1'b0;
      activeCount <= '0;
      txnCount    <= '0;
    end else if (strobe.capture) begin
      pending     <= reqActive;
      modeReg     <= lineMode;
      activeCount <= CNT_W'($countones(reqActive));
      txnCount    <= '0;
    end else if (strobe.issue) begin
      pending  <= pending & ~txnMask;
      txnCount <= txnCount + 1'b1;
    end
  end

  assign bytesUsed    = BYTE_W'(activeCount) * BYTE_W'(ELEM_BYTES);
  assign bytesFetched = BYTE_W'(txnCount) * (modeReg ? BYTE_W'(LINE_BYTES) : BYTE_W'(SECTOR_BYTES));

  // checker state: lanes already served in this warp
  logic [LANES-1:0] servedMask, activeReg;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      servedMask <= '0;
      activeReg  <= '0;
    end else if (strobe.capture) begin
      servedMask <= '0;
      activeReg  <= reqActive;
    end else if (strobe.issue) begin
      servedMask <= servedMask | txnMask;
    end
  end

  assert_disjoint_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> ((txnMask & servedMask) == '0));
  assert_union_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && (txnMask == pending)) |=> (servedMask == activeReg));
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    txnCount <= CNT_W'(LANES));
  assert_stable_txn_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pendingAny && !strobe.issue && !strobe.capture) |=> ($stable(txnBase) && $stable(txnMask)));
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coalesce_pkg::*;
#(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int ELEM_BYTES   = 4,
  parameter int SECTOR_BYTES = 32,
  parameter int LINE_BYTES   = 128
)(
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   lineMode,
  input  logic                                   reqValid,
  output logic                                   reqReady,
  input  logic [LANES-1:0]                       reqActive,
  input  logic [LANES*ADDR_W-1:0]                reqAddr,
  output logic                                   txnValid,
  input  logic                                   txnReady,
  output logic [ADDR_W-1:0]                      txnBase,
  output logic [LANES-1:0]                       txnMask,
  output logic                                   doneValid,
  output logic [$clog2(LANES+1)-1:0]             doneTxnCount,
  output logic [$clog2(LANES*LINE_BYTES+1)-1:0]  doneBytesUsed,
  output logic [$clog2(LANES*LINE_BYTES+1)-1:0]  doneBytesFetched
);
  strobe_t strobe;
  logic    pendingAny;

  coalesce_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .txnReady(txnReady),
    .pendingAny(pendingAny), .reqReady(reqReady), .txnValid(txnValid),
    .doneValid(doneValid), .strobe(strobe)
  );

  coalesce_dp #(
    .LANES(LANES), .ADDR_W(ADDR_W), .ELEM_BYTES(ELEM_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES), .LINE_BYTES(LINE_BYTES)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineMode(lineMode),
    .reqAddr(reqAddr), .reqActive(reqActive), .pendingAny(pendingAny),
    .txnBase(txnBase), .txnMask(txnMask), .txnCount(doneTxnCount),
    .bytesUsed(doneBytesUsed), .bytesFetched(doneBytesFetched)
  );
endmodule

// File: tb/sim_warp_coalescer.sv
module sim_warp_coalescer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineMode = 1'b0, reqValid = 1'b0, txnReady = 1'b0;
  logic [31:0] reqActive = '0;
  logic [1023:0] reqAddr = '0;
  logic reqReady, txnValid, doneValid;
  logic [31:0] txnBase, txnMask;
  logic [5:0] doneTxnCount;
  logic [12:0] doneBytesUsed, doneBytesFetched;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  warp_coalescer u0 (
    .clk(clk), .rstN(rstN), .lineMode(lineMode), .reqValid(reqValid),
    .reqReady(reqReady), .reqActive(reqActive), .reqAddr(reqAddr),
    .txnValid(txnValid), .txnReady(txnReady), .txnBase(txnBase),
    .txnMask(txnMask), .doneValid(doneValid), .doneTxnCount(doneTxnCount),
    .doneBytesUsed(doneBytesUsed), .doneBytesFetched(doneBytesFetched)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1023:0] strideAddr(input logic [31:0] base, input logic [31:0] stride);
    logic [1023:0] v;
    for (int i = 0; i < 32; i++) v[i*32 +: 32] = base + stride * i;
    return v;
  endfunction

  // One warp: reference segmentation, drive, collect, compare. expCount < 0 skips the fixed count.
  task automatic runWarp(input string name, input logic [1023:0] addrs, input logic [31:0] act,
                         input logic mode, input int stallMod, input int expCount);
    logic [31:0] refBase [32];
    logic [31:0] refMask [32];
    logic [31:0] left, keep, b;
    int nRef, nGot, cyc, segBytes, holdBase, holdMask;
    bit holdCheck, gotDone;
    segBytes = mode ? 128 : 32;
    keep = ~(segBytes - 1);
    left = act; nRef = 0;
    for (int i = 0; i < 32; i++) begin
      if (left[i]) begin
        b = addrs[i*32 +: 32] & keep;
        refBase[nRef] = b; refMask[nRef] = '0;
        for (int j = i; j < 32; j++)
          if (left[j] && ((addrs[j*32 +: 32] & keep) == b)) begin
            refMask[nRef][j] = 1'b1; left[j] = 1'b0;
          end
        nRef++;
      end
    end
    if (expCount >= 0) check(nRef == expCount, "R9", {name, " reference count"}, nRef, expCount);
    check(reqReady == 1'b1, "R1", {name, " ready before request"}, reqReady, 1);
    reqAddr = addrs; reqActive = act; lineMode = mode; reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0; lineMode = ~mode;  // changing mode after acceptance must not matter (R2)
    nGot = 0; cyc = 0; holdCheck = 0; gotDone = 0;
    if (act == 0) check(doneValid == 1'b1, "R5", {name, " empty warp done at once"}, doneValid, 1);
    while (!gotDone && cyc < 200) begin
      check(reqReady == 1'b0, "R1", {name, " no accept while busy"}, reqReady, 0);
      if (holdCheck) begin
        check(txnValid && txnBase == holdBase && txnMask == holdMask, "R7",
              {name, " stalled transaction held"}, txnBase, holdBase);
        holdCheck = 0;
      end
      if (doneValid) begin
        gotDone = 1;
        check(txnValid == 1'b0, "R1", {name, " no txn during done"}, txnValid, 0);
        check(doneTxnCount == nRef, "R6", {name, " txn count"}, doneTxnCount, nRef);
        check(doneBytesUsed == $countones(act) * 4, "R6", {name, " bytes used"},
              doneBytesUsed, $countones(act) * 4);
        check(doneBytesFetched == nRef * segBytes, "R6", {name, " bytes fetched"},
              doneBytesFetched, nRef * segBytes);
        if (expCount >= 0) check(doneTxnCount == expCount, "R9", {name, " pattern count"},
                                 doneTxnCount, expCount);
        txnReady = 1'b0;
      end else if (txnValid) begin
        txnReady = (stallMod == 0) ? 1'b1 : ((cyc % stallMod) != 0);
        if (txnReady) begin
          if (nGot < nRef) begin
            check(txnBase == refBase[nGot], "R2", {name, " base"}, txnBase, refBase[nGot]);
            check(txnMask == refMask[nGot], "R4", {name, " mask/order"}, txnMask, refMask[nGot]);
          end else check(0, "R3", {name, " extra transaction"}, nGot + 1, nRef);
          nGot++;
        end else begin
          holdCheck = 1; holdBase = txnBase; holdMask = txnMask;
        end
      end else txnReady = 1'b0;
      @(posedge clk); #1;
      cyc++;
    end
    check(gotDone, "R5", {name, " warp finished"}, gotDone, 1);
    check(nGot == nRef, "R3", {name, " transactions issued"}, nGot, nRef);
    txnReady = 1'b0;
    check(reqReady == 1'b1, "R1", {name, " ready after done"}, reqReady, 1);
  endtask

  task automatic testReset();
    check(reqReady == 1'b1, "R1", "reset reqReady", reqReady, 1);
    check(txnValid == 1'b0, "R1", "reset txnValid", txnValid, 0);
    check(doneValid == 1'b0, "R1", "reset doneValid", doneValid, 0);
  endtask

  task automatic testUnitStride();
    runWarp("unit sector", strideAddr(32'h1000, 4), '1, 1'b0, 0, 4);  // R9
    runWarp("unit line", strideAddr(32'h1000, 4), '1, 1'b1, 0, 1);
  endtask

  task automatic testShifted();
    runWarp("shift sector", strideAddr(32'h1004, 4), '1, 1'b0, 0, 5);  // R9
    runWarp("shift line", strideAddr(32'h1004, 4), '1, 1'b1, 3, 2);
  endtask

  task automatic testWideStride();
    runWarp("stride32 sector", strideAddr(32'h0, 32), '1, 1'b0, 2, 32);  // R9
    runWarp("stride4k line", strideAddr(32'h0, 4096), '1, 1'b1, 0, 32);
    runWarp("stride24 sector", strideAddr(32'h0, 24), '1, 1'b0, 0, 24);
  endtask

  task automatic testOrder();
    logic [1023:0] v;
    for (int i = 0; i < 32; i++) v[i*32 +: 32] = (31 - i) * 32;  // R4 reversed addresses
    runWarp("reverse sector", v, '1, 1'b0, 0, 32);
    for (int i = 0; i < 32; i++) v[i*32 +: 32] = (i % 3) * 256 + i;  // interleaved segments
    runWarp("interleave line", v, '1, 1'b1, 2, 3);
  endtask

  task automatic testInactive();
    logic [1023:0] v;
    v = strideAddr(32'h9000, 4096);
    v[0 +: 32] = 32'h0000_2004; v[31*32 +: 32] = 32'h0000_201C;
    runWarp("inactive ignored", v, 32'h8000_0001, 1'b0, 0, 1);  // R5
    runWarp("partial scattered", strideAddr(32'h40, 36), 32'h5A5A_F00F, 1'b0, 3, -1);
    runWarp("empty warp", strideAddr(32'h0, 4), 32'h0, 1'b0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testUnitStride();
    testShifted();
    testWideStride();
    testOrder();
    testInactive();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule